// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is an up-counting timer with two compare values, one asynchronous trigger input and one toggling output. A 3-bit mode field in an 8-bit control register selects one of four counting behaviours: stopped and held at zero, free-running, cleared by a trigger edge, or cleared after a compare-0 match. The low mode bit decides whether trigger edges also toggle the output. Each compare match produces a one-cycle interrupt pulse. Counter overflow sets a sticky flag that software can read and clear.

Counting advances only on cycles where the count-enable tick is high, so an external prescaler sets the rate. The trigger input is synchronised inside the block. A separate 2-bit input selects which trigger edges are valid. The surrounding bus logic drives the write strobe and data and reads back the control register.

Top module: `mtimer_unit`

## Requirements
- R1: After reset the control readback is 0x00, the counter is 0, the output is low and both interrupts are low. Readback bits 7..4 always read 0.
- R2: When mode bits 3..2 of the control register are 00 (mode 000 or 001), the counter is loaded with 0 on the next clock. Ticks have no effect, the output holds its level and no interrupt pulses.
- R3: In modes 010 and 011 the counter increments by one on each tick and wraps from 0xFFFF to 0x0000.
- R4: In modes 100 and 101, a valid trigger edge makes the next tick load 0 instead of incrementing. This applies to an edge seen in the same cycle as the tick or in any cycle since the last tick.
- R5: In modes 110 and 111, a tick with the counter equal to compare 0 loads 0.
- R6: In every running mode, the output inverts one cycle after a tick on which the counter equals compare 0 or compare 1. When both match on the same tick, it inverts only once.
- R7: When mode bit 1 (the low mode bit) is 1 in a running mode, a valid trigger edge also inverts the output one cycle later.
- R8: The compare-0 and compare-1 interrupts each pulse high for one cycle, one cycle after a tick on which the counter equals the matching compare value.
- R9: Readback bit 0 is set one cycle after the counter steps from 0xFFFF to 0 by increment. Edge-triggered clears do not set it.
- R10: In modes 11x with compare 0 at 0xFFFF, the match clear from 0xFFFF also sets readback bit 0.
- R11: Readback bit 0 stays set until a write with data bit 0 at 0. Writing 1 to it has no effect. A clearing write in the same cycle as an overflow leaves it set.
- R12: The trigger passes two synchronising flops before edge detection. Edge-select 01 selects rising edges, 10 selects falling edges, 11 selects both, and 00 selects none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Write data: bits 3..1 mode, bit 0 overflow clear (0 clears) |
| ctl_rdata | output | 8 | Readback: 0000, mode, overflow flag |
| cmp0 | input | 16 | Compare value 0 |
| cmp1 | input | 16 | Compare value 1 |
| tick | input | 1 | Count enable |
| trig_in | input | 1 | Asynchronous trigger input |
| edge_sel | input | 2 | Valid trigger edge selection |
| count | output | 16 | Current counter value |
| tmr_out | output | 1 | Toggling timer output |
| irq_cmp0 | output | 1 | Compare-0 match pulse |
| irq_cmp1 | output | 1 | Compare-1 match pulse |

## Verification
The assertions assume that every input holds a defined value from the first clock after reset release. They also assume that the mode field seen by the counter is exactly the value the control register last accepted, so that mode changes take effect at a clean clock boundary. The stimulus drives all inputs on the falling clock edge and sets each one before reset is released. It uses a mode write only as a full 8-bit write with the reserved bits at zero. It then moves the trigger, tick rate and compare values through each mode while a behavioural model tracks the expected state on every cycle.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

   localparam int CTL_W  = 8;
   localparam int MODE_W = 3;

   typedef enum logic [1:0] {
      RS_STOP  = 2'b00,
      RS_FREE  = 2'b01,
      RS_EDGE  = 2'b10,
      RS_MATCH = 2'b11
   } run_sel_e;

   function automatic run_sel_e run_sel_of(input logic [MODE_W-1:0] m);
      return run_sel_e'(m[MODE_W-1:1]);
   endfunction

endpackage

// File: rtl/mtmr_trig_sync.sv
module mtmr_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trig_in,
   input  logic [1:0] edge_sel,
   output logic       trig_evt
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("mtmr_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] sync_q;
   logic              prev_q;
   logic              lvl;
   logic              rise;
   logic              fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], trig_in};
         prev_q <= sync_q[STAGES-1];
      end
   end

   assign lvl      = sync_q[STAGES-1];
   assign rise     = lvl & ~prev_q;
   assign fall     = ~lvl & prev_q;
   assign trig_evt = (rise & edge_sel[0]) | (fall & edge_sel[1]);

endmodule

// File: rtl/mtmr_ctl.sv
module mtmr_ctl
   import mtmr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [3:0]        wdata,
   input  logic              ovf_evt,
   output logic [MODE_W-1:0] mode,
   output logic              ovf,
   output logic [CTL_W-1:0]  rdata
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
      end else if (we) begin
         mode <= wdata[MODE_W:1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf <= 1'b0;
      end else if (ovf_evt) begin
         ovf <= 1'b1;
      end else if (we && !wdata[0]) begin
         ovf <= 1'b0;
      end
   end

   assign rdata = {{(CTL_W-MODE_W-1){1'b0}}, mode, ovf};

   AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_evt |=> ovf); // R9
   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !(we && !wdata[0])) |=> ovf); // R11

endmodule

// File: rtl/mtmr_core.sv
module mtmr_core
   import mtmr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [MODE_W-1:0] mode,
   input  logic              tick,
   input  logic              trig_evt,
   input  logic [CNT_W-1:0]  cmp0,
   input  logic [CNT_W-1:0]  cmp1,
   output logic [CNT_W-1:0]  count,
   output logic              tout,
   output logic              irq0,
   output logic              irq1,
   output logic              ovf_evt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   run_sel_e sel;
   logic     run;
   logic     hit0;
   logic     hit1;
   logic     pend_q;
   logic     edge_clr;
   logic     match_clr;
   logic     tgl;

   assign sel       = run_sel_of(mode);
   assign run       = (sel != RS_STOP);
   assign hit0      = run & tick & (count == cmp0);
   assign hit1      = run & tick & (count == cmp1);
   assign edge_clr  = (sel == RS_EDGE) & (pend_q | trig_evt);
   assign match_clr = (sel == RS_MATCH) & hit0;
   assign ovf_evt   = run & tick & ~edge_clr & (count == CNT_MAX);
   assign tgl       = run & (hit0 | hit1 | (mode[0] & trig_evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count  <= '0;
         pend_q <= 1'b0;
      end else if (!run) begin
         count  <= '0;
         pend_q <= 1'b0;
      end else if (tick) begin
         pend_q <= 1'b0;
         if (edge_clr || match_clr) begin
            count <= '0;
         end else begin
            count <= count + 1'b1;
         end
      end else begin
         pend_q <= edge_clr;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq0 <= 1'b0;
         irq1 <= 1'b0;
         tout <= 1'b0;
      end else begin
         irq0 <= hit0;
         irq1 <= hit1;
         if (tgl) begin
            tout <= ~tout;
         end
      end
   end

   AST_STOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (count == '0)); // R2
   AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> $stable(tout)); // R2
   AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!irq0 && !irq1)); // R8
   AST_FREE_INC: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == RS_FREE && tick) |=> (count == CNT_W'($past(count) + 1'b1))); // R3

endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
   import mtmr_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic [CTL_W-1:0] ctl_wdata,
   output logic [CTL_W-1:0] ctl_rdata,
   input  logic [CNT_W-1:0] cmp0,
   input  logic [CNT_W-1:0] cmp1,
   input  logic             tick,
   input  logic             trig_in,
   input  logic [1:0]       edge_sel,
   output logic [CNT_W-1:0] count,
   output logic             tmr_out,
   output logic             irq_cmp0,
   output logic             irq_cmp1
);

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("mtimer_unit: CNT_W must lie in 2..32");
      end
   endgenerate

   logic              trig_evt;
   logic              ovf_evt;
   logic              ovf;
   logic [MODE_W-1:0] mode;
   logic              unused_wr_hi;

   assign unused_wr_hi = ^ctl_wdata[CTL_W-1:4] ^ ovf;

   mtmr_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .edge_sel (edge_sel),
      .trig_evt (trig_evt)
   );

   mtmr_ctl u_ctl (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (ctl_we),
      .wdata   (ctl_wdata[3:0]),
      .ovf_evt (ovf_evt),
      .mode    (mode),
      .ovf     (ovf),
      .rdata   (ctl_rdata)
   );

   mtmr_core #(.CNT_W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .tick     (tick),
      .trig_evt (trig_evt),
      .cmp0     (cmp0),
      .cmp1     (cmp1),
      .count    (count),
      .tout     (tmr_out),
      .irq0     (irq_cmp0),
      .irq1     (irq_cmp1),
      .ovf_evt  (ovf_evt)
   );

endmodule

// File: tb/sim_mtimer_unit.sv
module sim_mtimer_unit;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ctl_we = 1'b0;
   logic [7:0]  ctl_wdata = 8'h00;
   logic [7:0]  ctl_rdata;
   logic [15:0] cmp0 = 16'h0000;
   logic [15:0] cmp1 = 16'h0000;
   logic        tick = 1'b0;
   logic        trig_in = 1'b0;
   logic [1:0]  edge_sel = 2'b11;
   logic [15:0] count;
   logic        tmr_out;
   logic        irq_cmp0;
   logic        irq_cmp1;

   always #(CLK_NS/2) clk = ~clk;

   mtimer_unit u0 (
      .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
      .ctl_rdata(ctl_rdata), .cmp0(cmp0), .cmp1(cmp1), .tick(tick),
      .trig_in(trig_in), .edge_sel(edge_sel), .count(count),
      .tmr_out(tmr_out), .irq_cmp0(irq_cmp0), .irq_cmp1(irq_cmp1)
   );

   int    vectors = 0;
   int    miscmp = 0;
   string req = "R1";
   bit    chk_en = 1'b0;
   bit    done = 1'b0;

   // behavioural reference state
   int m_cnt, m_tout, m_irq0, m_irq1, m_mode, m_ovf, m_pend, t1, t2, t3;

   always @(posedge clk) begin : model
      int grp, ev, run, h0, h1, eclr, ovfe, tg;
      if (!rst_n) begin
         m_cnt = 0; m_tout = 0; m_irq0 = 0; m_irq1 = 0; m_mode = 0;
         m_ovf = 0; m_pend = 0; t1 = 0; t2 = 0; t3 = 0;
      end else begin
         grp  = m_mode / 2;
         ev   = ((t2 == 1 && t3 == 0 && edge_sel[0]) ||
                 (t2 == 0 && t3 == 1 && edge_sel[1])) ? 1 : 0;
         run  = (grp != 0) ? 1 : 0;
         h0   = (run == 1 && tick && m_cnt == int'(cmp0)) ? 1 : 0;
         h1   = (run == 1 && tick && m_cnt == int'(cmp1)) ? 1 : 0;
         eclr = (grp == 2 && (m_pend == 1 || ev == 1)) ? 1 : 0;
         ovfe = (run == 1 && tick && eclr == 0 && m_cnt == 65535) ? 1 : 0;
         tg   = (run == 1 && (h0 == 1 || h1 == 1 || (m_mode % 2 == 1 && ev == 1))) ? 1 : 0;
         if (run == 0) begin
            m_cnt = 0; m_pend = 0;
         end else if (tick) begin
            m_pend = 0;
            if (eclr == 1 || (grp == 3 && h0 == 1)) m_cnt = 0;
            else m_cnt = (m_cnt + 1) % 65536;
         end else begin
            m_pend = eclr;
         end
         m_irq0 = h0; m_irq1 = h1;
         if (tg == 1) m_tout = 1 - m_tout;
         if (ovfe == 1) m_ovf = 1;
         else if (ctl_we && !ctl_wdata[0]) m_ovf = 0;
         if (ctl_we) m_mode = int'(ctl_wdata[3:1]);
         t3 = t2; t2 = t1; t1 = int'(trig_in);
      end
   end

   task automatic cmp(input string nm, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         miscmp++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, nm, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (chk_en && !done) begin
         cmp("count", int'(count), m_cnt);
         cmp("tmr_out", int'(tmr_out), m_tout);
         cmp("irq_cmp0", int'(irq_cmp0), m_irq0);
         cmp("irq_cmp1", int'(irq_cmp1), m_irq1);
         cmp("ctl_rdata", int'(ctl_rdata), m_mode * 2 + m_ovf);
      end
   end

   int tper = 1;
   int tph = 0;
   always @(negedge clk) begin
      tph++;
      tick = ((tph % tper) == 0);
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] m, input logic o);
      @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = {4'b0000, m, o};
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic pulses(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         trig_in = ~trig_in;
         cyc(gap);
      end
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
      $finish;
   endtask

   initial begin
      #(CLK_NS * 190000);
      miscmp++;
      $display("FAIL watchdog expired in phase %s", req);
      finish_run();
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      chk_en = 1'b1;
      // R1 reset state
      req = "R1";
      cyc(2);
      cmp("reset ctl_rdata", int'(ctl_rdata), 0);
      cmp("reset count", int'(count), 0);
      cmp("reset tmr_out", int'(tmr_out), 0);
      // R2 stopped: ticks ignored
      req = "R2";
      cmp0 = 16'd3; cmp1 = 16'd0;
      cyc(10);
      cmp("stopped count", int'(count), 0);
      wr(3'b001, 1'b1);
      cyc(10);
      cmp("mode 001 count", int'(count), 0);
      // R3 / R6 / R8 free running
      req = "R3";
      cmp0 = 16'd5; cmp1 = 16'd9;
      wr(3'b010, 1'b1);
      cyc(40);
      req = "R6";
      tper = 3;
      cmp1 = 16'd5;
      cyc(60);
      req = "R8";
      tper = 1;
      cmp0 = 16'd100; cmp1 = 16'd110;
      cyc(40);
      // R7 edge toggle
      req = "R7";
      edge_sel = 2'b11;
      wr(3'b011, 1'b1);
      pulses(10, 7);
      // R4 edge clear
      req = "R4";
      edge_sel = 2'b01;
      wr(3'b100, 1'b1);
      pulses(8, 13);
      tper = 4;
      wr(3'b101, 1'b1);
      pulses(8, 11);
      tper = 1;
      // R12 edge selection and synchroniser delay
      req = "R12";
      edge_sel = 2'b10;
      pulses(8, 9);
      edge_sel = 2'b00;
      pulses(8, 9);
      edge_sel = 2'b11;
      pulses(6, 1);
      pulses(6, 5);
      // R5 clear on compare 0
      req = "R5";
      cmp0 = 16'd20; cmp1 = 16'd7;
      wr(3'b110, 1'b1);
      cyc(80);
      wr(3'b111, 1'b1);
      pulses(6, 10);
      // R2 stop mid-count holds output
      req = "R2";
      wr(3'b000, 1'b1);
      cyc(5);
      cmp("stop mid count", int'(count), 0);
      // R9 free-run wrap
      req = "R9";
      cmp0 = 16'd100; cmp1 = 16'd200;
      wr(3'b010, 1'b1);
      while (count != 16'hFFF0) @(negedge clk);
      cyc(20);
      cmp("overflow flag", int'(ctl_rdata[0]), 1);
      // R11 sticky flag
      req = "R11";
      wr(3'b010, 1'b1);
      cyc(2);
      cmp("write 1 keeps flag", int'(ctl_rdata[0]), 1);
      wr(3'b010, 1'b0);
      cyc(1);
      cmp("write 0 clears flag", int'(ctl_rdata[0]), 0);
      // R10 clear at match with compare 0 = 0xFFFF
      req = "R10";
      cmp0 = 16'hFFFF; cmp1 = 16'h8000;
      wr(3'b110, 1'b1);
      while (count != 16'hFFFF) @(negedge clk);
      ctl_we = 1'b1;
      ctl_wdata = 8'b0000_1100;
      @(negedge clk);
      ctl_we = 1'b0;
      cmp("flag set despite clearing write", int'(ctl_rdata[0]), 1);
      cmp("cleared at match", int'(count), 0);
      cyc(10);
      wr(3'b110, 1'b0);
      cyc(2);
      cmp("flag cleared later", int'(ctl_rdata[0]), 0);
      finish_run();
   end
endmodule